// File: doc/BRIEF.md
# Event Counter Bank with Threshold Overflow Interrupt

This block is a small performance-monitor unit. It holds a parameterised number of 32-bit event counters. Counter 0 is fed by read-beat pulses and counter 1 by write-beat pulses. Any further counters take the higher event inputs. A counter advances only when three conditions hold together: the global run bit is on, its own count-enable bit is on, and its event pulse is high in that cycle.

Software reaches every register through a plain register bus. The bus carries an address, a write strobe, write data, and read data that follows the address combinationally. Count enables and interrupt enables each have two aliases. Writing ones to the set alias turns bits on. Writing ones to the clear alias turns bits off. Zero bits change nothing, and either alias reads back the current mask.

When a counter rolls over from all-ones to zero, it raises a sticky overflow bit. Software clears that bit by writing a one to it. If software loads a counter with all-ones minus a budget, the overflow bit works as a "budget used up" alarm. A level interrupt is the OR, over all counters, of the overflow bit and the interrupt-enable bit of the same counter.

Top module: `pmu_event_bank`

Register offsets (word addresses): 0 run control, 1 count-enable set, 2 count-enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow status, 8+n counter n.

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: Bit 0 of the run-control register (offset 0) is the global run bit. While it is 0, no counter changes on events. The register reads back bit 0 only, and the upper bits read as 0.
- R3: Writing ones to the count-enable set alias (offset 1) sets those enable bits. Writing ones to the clear alias (offset 2) clears them. Zero bits have no effect, and both aliases read the current mask, where bit n belongs to counter n.
- R4: Counter n adds exactly 1 at each clock edge where `evt_i[n]`, its enable and the run bit are all 1. Bit 0 of `evt_i` is the read-beat input and bit 1 is the write-beat input.
- R5: A write to offset 8+n loads counter n with the write data. A write in the same cycle as a qualified event for that counter wins, and the event is dropped.
- R6: A counter that holds 0xFFFFFFFF and takes one more event wraps to 0 and sets overflow bit n. A start value S therefore overflows on event number 0xFFFFFFFF−S+1.
- R7: The overflow status register (offset 5) is sticky. Writing a 1 to bit n clears it, and zero bits have no effect.
- R8: If a clear write and a new overflow hit the same overflow bit in the same cycle, the bit ends up set.
- R9: Interrupt enables use set and clear aliases (offsets 3 and 4) with the same scheme as R3. `irq_o` is high exactly while some overflow bit and its interrupt-enable bit are both 1, so it stays high until software clears one of them.
- R10: An overflow is recorded while its interrupt enable is 0, and `irq_o` stays low. Turning the enable on afterwards raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CNT | Event pulses; bit 0 read beats, bit 1 write beats |
| addr_i | input | ADDR_W | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The counters are driven with read-only, write-only and simultaneous beat patterns. Each counter must then show its own total, which separates a wrong event mapping from a shared increment path. The same beats are also sent with the run bit off and with one enable cleared, so a gating bug shows up as a non-zero count. A preload just below all-ones is stepped one event at a time. This locates the exact event that raises overflow and tells an early wrap from a late one. Two same-cycle collisions are also tried: a load against an event, and a clear against a new overflow. These expose which side of each priority the design takes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   // register word offsets
   localparam int OFF_RUN     = 0;
   localparam int OFF_CEN_SET = 1;
   localparam int OFF_CEN_CLR = 2;
   localparam int OFF_IEN_SET = 3;
   localparam int OFF_IEN_CLR = 4;
   localparam int OFF_OVF     = 5;
   localparam int OFF_CNT0    = 8;
endpackage

// File: rtl/pmu_w1_mask.sv
module pmu_w1_mask #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] bits,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (set_we) mask_q <= mask_q | bits;
      else if (clr_we) mask_q <= mask_q & ~bits;
   end

   assign mask_o = mask_q;

   // R3
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((mask_q & $past(bits)) == $past(bits)));
   // R3
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((mask_q & $past(bits)) == '0));
   // R3
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step   = inc && !ld_en;
   assign wrap_o = step && (&cnt_q);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (ld_en) cnt_q <= ld_val;
      else if (inc)   cnt_q <= cnt_q + CNT_W'(1);
   end

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !ld_en) |=> $stable(cnt_q));
   // R5
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (cnt_q == $past(ld_val)));
   // R6
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_we,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] set_bits,
   output logic [N-1:0] stat_o
);
   logic [N-1:0] stat_q;
   logic [N-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_eff) | set_bits;
   end

   assign stat_o = stat_q;

   for (genvar n = 0; n < N; n++) begin : g_bit
      // R8
      ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_bits[n] |=> stat_q[n]);
      // R7
      ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && clr_bits[n] && !set_bits[n]) |=> !stat_q[n]);
      // R7
      ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[n] && !(clr_we && clr_bits[n])) |=> stat_q[n]);
   end
endmodule

// File: rtl/pmu_event_bank.sv
module pmu_event_bank
   import pmu_pkg::*;
#(
   parameter int NUM_CNT = 2,
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CNT-1:0] evt_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_o
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (NUM_CNT < 2 || NUM_CNT > DATA_W) begin : g_bad_num
      $error("NUM_CNT must lie in 2..DATA_W");
   end
   if (CNT_W != DATA_W) begin : g_bad_w
      $error("CNT_W must equal DATA_W");
   end
   if (OFF_CNT0 + NUM_CNT > ADDR_SPAN) begin : g_bad_addr
      $error("counter window exceeds address space");
   end

   logic               run_q;
   logic [NUM_CNT-1:0] cen, ien, ovf, wrap;
   logic [NUM_CNT-1:0] bits;
   logic [CNT_W-1:0]   cnt [NUM_CNT];

   logic wr_run, wr_cen_s, wr_cen_c, wr_ien_s, wr_ien_c, wr_ovf;

   assign bits     = wdata_i[NUM_CNT-1:0];
   assign wr_run   = we_i && (addr_i == ADDR_W'(OFF_RUN));
   assign wr_cen_s = we_i && (addr_i == ADDR_W'(OFF_CEN_SET));
   assign wr_cen_c = we_i && (addr_i == ADDR_W'(OFF_CEN_CLR));
   assign wr_ien_s = we_i && (addr_i == ADDR_W'(OFF_IEN_SET));
   assign wr_ien_c = we_i && (addr_i == ADDR_W'(OFF_IEN_CLR));
   assign wr_ovf   = we_i && (addr_i == ADDR_W'(OFF_OVF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= 1'b0;
      else if (wr_run) run_q <= wdata_i[0];
   end

   pmu_w1_mask #(.W(NUM_CNT)) u_cen (
      .clk(clk), .rst_n(rst_n), .set_we(wr_cen_s), .clr_we(wr_cen_c),
      .bits(bits), .mask_o(cen)
   );

   pmu_w1_mask #(.W(NUM_CNT)) u_ien (
      .clk(clk), .rst_n(rst_n), .set_we(wr_ien_s), .clr_we(wr_ien_c),
      .bits(bits), .mask_o(ien)
   );

   for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
      logic ld;
      assign ld = we_i && (addr_i == ADDR_W'(OFF_CNT0 + n));
      pmu_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .ld_en(ld), .ld_val(wdata_i[CNT_W-1:0]),
         .inc(run_q && cen[n] && evt_i[n]), .cnt_o(cnt[n]), .wrap_o(wrap[n])
      );
   end

   pmu_ovf_status #(.N(NUM_CNT)) u_ovf (
      .clk(clk), .rst_n(rst_n), .clr_we(wr_ovf), .clr_bits(bits),
      .set_bits(wrap), .stat_o(ovf)
   );

   assign irq_o = |(ovf & ien);

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(OFF_RUN):     rdata_o = DATA_W'(run_q);
         ADDR_W'(OFF_CEN_SET),
         ADDR_W'(OFF_CEN_CLR): rdata_o = DATA_W'(cen);
         ADDR_W'(OFF_IEN_SET),
         ADDR_W'(OFF_IEN_CLR): rdata_o = DATA_W'(ien);
         ADDR_W'(OFF_OVF):     rdata_o = DATA_W'(ovf);
         default: ;
      endcase
      for (int n = 0; n < NUM_CNT; n++) begin
         if (addr_i == ADDR_W'(OFF_CNT0 + n)) rdata_o = cnt[n];
      end
   end

   // R2
   run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (wrap == '0));
   // R9
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(wr_ovf || wr_ien_c));
   // R10
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(wrap != '0) || $past(wr_ien_s)));
endmodule

// File: tb/tb_pmu_event_bank.sv
module tb_pmu_event_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CNT = 2;
   localparam int ADDR_W  = 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_CNT-1:0] evt = '0;
   logic [ADDR_W-1:0]  addr = '0;
   logic               we = 1'b0;
   logic [31:0]        wdata = '0;
   logic [31:0]        rdata;
   logic               irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];
   bit    rd_valid = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmu_event_bank #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr), .we_i(we),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   // monitor: compares against queued expectations
   always @(negedge clk) begin
      if (rd_valid && sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         act = it.is_irq ? {31'd0, irq} : rdata;
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      addr = ADDR_W'(a); wdata = d; we = 1'b1;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      addr = ADDR_W'(a); we = 1'b0;
      it.is_irq = 0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      rd_valid = 1;
      @(posedge clk); #1;
      rd_valid = 0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1; it.exp = {31'd0, e}; it.tag = tag;
      sb_q.push_back(it);
      rd_valid = 1;
      @(posedge clk); #1;
      rd_valid = 0;
   endtask

   task automatic events(input logic [NUM_CNT-1:0] m, input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         evt = m;
      end
      @(posedge clk); #1;
      evt = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      rd(0, 0, "R1 run");
      rd(1, 0, "R1 cen");
      rd(3, 0, "R1 ien");
      rd(5, 0, "R1 ovf");
      rd(8, 0, "R1 cnt0");
      rd(9, 0, "R1 cnt1");
      chk_irq(0, "R1 irq");

      // R2 run bit readback, only bit 0
      wr(0, 32'hFFFF_FFFF);
      rd(0, 1, "R2 run readback");
      wr(0, 0);
      // R3 enable set and both aliases
      wr(1, 3);
      rd(1, 3, "R3 set alias");
      rd(2, 3, "R3 clr alias");
      // R2 no counting while stopped
      events(2'b11, 5);
      rd(8, 0, "R2 cnt0 stopped");
      rd(9, 0, "R2 cnt1 stopped");

      // R4 patterns
      wr(0, 1);
      events(2'b01, 5);
      events(2'b10, 3);
      events(2'b11, 2);
      rd(8, 7, "R4 cnt0 read beats");
      rd(9, 5, "R4 cnt1 write beats");

      // R3 clear one, zero bits no effect
      wr(2, 1);
      rd(1, 2, "R3 after clear");
      wr(1, 0);
      rd(2, 2, "R3 zero set no effect");
      events(2'b11, 4);
      rd(8, 7, "R3 cnt0 disabled");
      rd(9, 9, "R3 cnt1 enabled");

      // R5 load, R6 threshold
      wr(1, 3);
      wr(8, 32'hFFFF_FFFC);
      rd(8, 32'hFFFF_FFFC, "R5 load");
      events(2'b01, 3);
      rd(8, 32'hFFFF_FFFF, "R6 before wrap");
      rd(5, 0, "R6 no early ovf");
      events(2'b01, 1);
      rd(8, 0, "R6 wrapped");
      rd(5, 1, "R6 ovf set");
      chk_irq(0, "R10 irq masked");

      // R10 / R9
      wr(3, 1);
      rd(4, 1, "R9 ien alias");
      chk_irq(1, "R10 irq after enable");
      wr(5, 0);
      rd(5, 1, "R7 zero write no effect");
      chk_irq(1, "R9 irq held");
      wr(5, 1);
      rd(5, 0, "R7 cleared");
      chk_irq(0, "R9 irq dropped");

      // R5 write beats same-cycle event
      @(posedge clk); #1;
      addr = 6'd8; wdata = 32'h100; we = 1'b1; evt = 2'b01;
      @(posedge clk); #1;
      we = 1'b0; evt = '0;
      rd(8, 32'h100, "R5 load wins over event");

      // R8 overflow wins over clear
      wr(3, 2);
      wr(9, 32'hFFFF_FFFF);
      events(2'b10, 1);
      rd(5, 2, "R8 first ovf");
      wr(9, 32'hFFFF_FFFF);
      @(posedge clk); #1;
      addr = 6'd5; wdata = 32'h2; we = 1'b1; evt = 2'b10;
      @(posedge clk); #1;
      we = 1'b0; evt = '0;
      rd(5, 2, "R8 set wins");
      rd(9, 0, "R8 cnt1 wrapped");
      chk_irq(1, "R9 irq cnt1");
      wr(4, 2);
      chk_irq(0, "R9 irq after ien clear");
      rd(5, 2, "R9 ovf kept");

      repeat (2) @(posedge clk);
      if (sb_q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard: actual=%0d expected=0 pending", sb_q.size());
      end
      finish_run();
   end
endmodule